// File: doc/BRIEF.md
# I2C Read Master with Run-Ahead Receive Buffer

This block is the master side of an I2C bus for read transactions only. A start pulse makes it issue a START condition and send a 7-bit target address with the read bit. It then clocks data bytes in from the target. Each completed byte is copied into a holding register and flagged to software, and the shifter carries on with the next byte straight away. The bus is held only when going further would overwrite an unread byte.

A read is ended in one of two ways. Software can pulse a stop request. Otherwise, a nonzero byte count given with the start ends the read by itself after that many bytes. Either way, the final byte gets a NACK and is followed by a STOP, so the target never has to supply a byte that nobody wants. Both lines are open-drain. The block drives an output enable that pulls the line low, and it reads the wired line back. Timing comes from dividing the system clock: one bit lasts four quarter periods of `QTR` system clocks each. A target that holds SCL low stretches the high phase.

Top module: `i2c_rd_master`

## Requirements
- R1: When the eighth data bit of a byte has been sampled, that byte appears on `rx_data` and `rx_ready` rises. Clocking of the following byte begins without any `rd_ack`. A byte that is still pending is never overwritten; a one-cycle `rd_ack` pulse clears `rx_ready`.
- R2: If `rx_ready` is still high when seven bits of the following byte have been clocked, SCL is held low. No eighth rising edge occurs until `rd_ack` has cleared `rx_ready`.
- R3: An accepted `start_req` raises `start_pend` and `busy` in the next cycle. The address goes out MSB first, followed by a read bit of 1. `start_pend` stays high until the address acknowledge clock is over, then clears without setting `rx_ready`.
- R4: A `stop_req` pulse while busy makes the byte currently being received the last one, provided its acknowledge level is still undecided. A stop requested during the first data byte therefore yields exactly one byte.
- R5: With `byte_cnt` = N > 0 latched at start, exactly N bytes are read. Bytes 1..N-1 are acknowledged by pulling SDA low on the ninth clock. Byte N is NACKed (SDA released), and a STOP follows without any software action. With N = 0, only `stop_req` ends the read.
- R6: While busy, SDA changes while SCL is high only in two cases: a falling edge as START (with `start_pend` high), and a rising edge as STOP (with `busy` low from that cycle).
- R7: If the address is not acknowledged, `nack_flag` is set, STOP follows, no data byte is clocked, and the block goes idle. The next accepted start clears `nack_flag`.
- R8: While a target holds SCL low, the high phase is not counted. The high phase is timed from the cycle SCL is seen high, so data under clock stretching is received unchanged.
- R9: `busy` is high from the START until the STOP has finished. A `start_req` while busy is ignored.
- R10: After reset both lines are released, and `busy`, `start_pend`, `rx_ready` and `nack_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Pulse: begin a read transaction when idle |
| stop_req | input | 1 | Pulse: end the read after the current byte |
| addr | input | 7 | Target address, latched at start |
| byte_cnt | input | CW | Bytes to read, 0 = software stop only |
| rd_ack | input | 1 | Pulse: software has taken `rx_data` |
| rx_data | output | 8 | Receive holding register |
| rx_ready | output | 1 | Holding register contains an unread byte |
| busy | output | 1 | Transaction in progress |
| start_pend | output | 1 | START and address phase in progress |
| nack_flag | output | 1 | Last address was not acknowledged |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| scl_in | input | 1 | Wired SCL level |
| sda_in | input | 1 | Wired SDA level |

## Verification
The bench builds the block with `QTR` = 2, which makes a bit eight system clocks long. At that length, a multi-byte read, a deliberate several-hundred-cycle stall while a byte sits unread, and a stretched clock all fit in a short run. `CW` = 4 is enough for the counts of 1 to 3 that the bench uses. The bench attaches a byte-serving target model whose data pointer advances per fetched byte. This makes the count of bytes actually pulled from the target observable, which is the quantity that stop timing and the byte count must control.

// File: rtl/i2c_rd_master.sv
module i2c_rd_master #(
  parameter int QTR = 25,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic [6:0]    addr,
  input  logic [CW-1:0] byte_cnt,
  input  logic          rd_ack,
  output logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          busy,
  output logic          start_pend,
  output logic          nack_flag,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          scl_in,
  input  logic          sda_in
);
  localparam int TW = (QTR > 1) ? $clog2(QTR) : 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_XFER, S_STOP} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic          is_data, last_q, ack_s, stop_pend;
  logic [7:0]    shreg;
  logic [CW-1:0] cnt_q, nbytes;

  assign busy = (st != S_IDLE);

  wire stall   = (st == S_XFER) && is_data && (bitn == 4'd7) && (ph == 2'd0) && rx_ready;
  wire wait_hi = ((st == S_XFER) || (st == S_STOP)) && (ph == 2'd2) && !scl_in;
  wire step    = busy && !stall && !wait_hi && (tmr == TW'(QTR - 1));
  wire last    = stop_pend || stop_req || ((cnt_q != '0) && (nbytes == cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmr <= '0;
      ph <= 2'd0;
      bitn <= 4'd0;
      is_data <= 1'b0;
      last_q <= 1'b0;
      ack_s <= 1'b0;
      stop_pend <= 1'b0;
      shreg <= 8'd0;
      cnt_q <= '0;
      nbytes <= '0;
      rx_data <= 8'd0;
      rx_ready <= 1'b0;
      start_pend <= 1'b0;
      nack_flag <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      if (rd_ack) rx_ready <= 1'b0;
      if (stop_req && busy) stop_pend <= 1'b1;

      if (!busy || stall || wait_hi || step) tmr <= '0;
      else tmr <= tmr + TW'(1);

      case (st)
        S_IDLE: if (start_req) begin
          st <= S_START;
          ph <= 2'd0;
          start_pend <= 1'b1;
          nack_flag <= 1'b0;
          stop_pend <= 1'b0;
          cnt_q <= byte_cnt;
          nbytes <= '0;
          shreg <= {addr, 1'b1};
          sda_oe <= 1'b1;
        end
        S_START: if (step) begin
          if (ph == 2'd0) ph <= 2'd1;
          else begin
            ph <= 2'd0;
            st <= S_XFER;
            scl_oe <= 1'b1;
            bitn <= 4'd0;
            is_data <= 1'b0;
          end
        end
        S_XFER: if (step) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: begin
              if (bitn == 4'd8) begin
                sda_oe <= is_data && !last;
                last_q <= last;
              end else begin
                sda_oe <= !is_data && !shreg[7];
              end
            end
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              if (bitn == 4'd8) ack_s <= sda_in;
              else shreg <= {shreg[6:0], sda_in};
              if (is_data && bitn == 4'd7) begin
                rx_data <= {shreg[6:0], sda_in};
                rx_ready <= 1'b1;
                nbytes <= nbytes + CW'(1);
              end
            end
            default: begin
              scl_oe <= 1'b1;
              if (bitn != 4'd8) bitn <= bitn + 4'd1;
              else begin
                bitn <= 4'd0;
                if (!is_data) begin
                  start_pend <= 1'b0;
                  if (ack_s) begin
                    nack_flag <= 1'b1;
                    st <= S_STOP;
                  end else begin
                    is_data <= 1'b1;
                  end
                end else if (last_q) begin
                  st <= S_STOP;
                end
              end
            end
          endcase
        end
        default: if (step) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: ;
            default: begin
              sda_oe <= 1'b0;
              st <= S_IDLE;
            end
          endcase
        end
      endcase
    end
  end
endmodule

module i2c_rd_master_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_req,
  input logic          rd_ack,
  input logic [7:0]    rx_data,
  input logic          rx_ready,
  input logic          busy,
  input logic          start_pend,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          scl_in,
  input logic          stall,
  input logic [CW-1:0] nbytes,
  input logic [CW-1:0] cnt_q
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else armed <= 1'b1;

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    rx_ready && !rd_ack |=> rx_ready && $stable(rx_data)); // R1
  AST_STALL_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    stall |=> scl_oe); // R2
  AST_START_PEND_BUSY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    start_pend |-> busy); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (cnt_q != '0) |-> (nbytes <= cnt_q)); // R5
  AST_SDA_FALL_HIGH_IS_START: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(sda_oe) && scl_in && $past(scl_in) |-> start_pend); // R6
  AST_SDA_RISE_HIGH_IS_STOP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $fell(sda_oe) && scl_in && $past(scl_in) |-> !busy); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    busy && !start_pend && start_req |=> !start_pend); // R9
endmodule

bind i2c_rd_master i2c_rd_master_chk #(.CW(CW)) u_chk (.*);

// File: tb/i2c_rd_master_tb_top.sv
`timescale 1ns/1ps
module i2c_rd_master_tb_top;
  localparam int QTR = 2;
  localparam int CW  = 4;
  localparam logic [6:0] SLV = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_req = 1'b0, stop_req = 1'b0, rd_ack = 1'b0;
  logic [6:0] addr = 7'd0;
  logic [CW-1:0] byte_cnt = '0;
  logic [7:0] rx_data;
  logic rx_ready, busy, start_pend, nack_flag, scl_oe, sda_oe;
  logic scl_in, sda_in;
  logic s_sda_low, s_scl_hold;

  assign scl_in = !(scl_oe || s_scl_hold);
  assign sda_in = !(sda_oe || s_sda_low);

  always #2.5 clk = ~clk;

  i2c_rd_master #(.QTR(QTR), .CW(CW)) dut_i (.*);

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input int i);
    return 8'((i * 37) + 8'h11);
  endfunction

  // behavioural target: serves mem[ptr], ptr advances per fetched byte
  logic ps, pd, s_match, s_mack;
  int s_st, s_k, s_ptr, stops, m_acks, m_nacks, stretch_len, s_hold_cnt;
  logic [7:0] s_sh, s_byte;

  always @(posedge clk) begin
    if (!rst_n) begin
      ps <= 1'b1; pd <= 1'b1; s_st <= 0; s_k <= 0; s_ptr <= 0; stops <= 0;
      m_acks <= 0; m_nacks <= 0; s_hold_cnt <= 0; s_sda_low <= 1'b0;
      s_scl_hold <= 1'b0; s_match <= 1'b0; s_mack <= 1'b0; s_sh <= 8'd0; s_byte <= 8'd0;
    end else begin
      ps <= scl_in; pd <= sda_in;
      if (s_hold_cnt > 0) begin
        s_hold_cnt <= s_hold_cnt - 1;
        if (s_hold_cnt == 1) s_scl_hold <= 1'b0;
      end
      if (ps && scl_in && pd && !sda_in) begin
        s_st <= 1; s_k <= 0; s_sda_low <= 1'b0;
      end else if (ps && scl_in && !pd && sda_in) begin
        s_st <= 0; stops <= stops + 1; s_sda_low <= 1'b0;
      end else if (!ps && scl_in) begin
        if (s_st == 1) begin
          if (s_k < 8) s_sh <= {s_sh[6:0], sda_in};
          s_k <= s_k + 1;
        end else if (s_st == 2) begin
          if (s_k == 8) s_mack <= !sda_in;
          s_k <= s_k + 1;
        end
      end else if (ps && !scl_in) begin
        if (s_st == 1) begin
          if (s_k == 8) begin
            s_match <= (s_sh[7:1] == SLV) && s_sh[0];
            s_sda_low <= (s_sh[7:1] == SLV) && s_sh[0];
          end else if (s_k == 9) begin
            if (s_match) begin
              s_st <= 2; s_k <= 0; s_byte <= mem(s_ptr); s_ptr <= s_ptr + 1;
              s_sda_low <= !mem(s_ptr)[7];
              if (stretch_len > 0) begin s_scl_hold <= 1'b1; s_hold_cnt <= stretch_len; end
            end else begin
              s_st <= 3; s_sda_low <= 1'b0;
            end
          end
        end else if (s_st == 2) begin
          if (s_k < 8) s_sda_low <= !s_byte[7 - s_k];
          else if (s_k == 8) s_sda_low <= 1'b0;
          else if (s_mack) begin
            m_acks <= m_acks + 1; s_k <= 0; s_byte <= mem(s_ptr); s_ptr <= s_ptr + 1;
            s_sda_low <= !mem(s_ptr)[7];
            if (stretch_len > 0) begin s_scl_hold <= 1'b1; s_hold_cnt <= stretch_len; end
          end else begin
            m_nacks <= m_nacks + 1; s_sda_low <= 1'b0; s_st <= 3;
          end
        end
      end
    end
  end

  // per-clock line monitor
  logic m_scl = 1'b1, m_sda = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_scl && scl_in && (m_sda != sda_in)) begin
        if (!sda_in) chk(start_pend === 1'b1, "R6 start edge", start_pend, 1);
        else chk(busy === 1'b0, "R6 stop edge", busy, 0);
      end
      if (!m_scl && scl_in && s_st == 2 && s_k == 7)
        chk(rx_ready === 1'b0, "R2 eighth rise with unread byte", rx_ready, 0);
    end
    m_scl <= scl_in; m_sda <= sda_in;
  end

  task automatic do_start(input logic [6:0] a, input int n);
    @(negedge clk); addr = a; byte_cnt = CW'(n); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] d);
    while (!rx_ready) @(negedge clk);
    d = rx_data; rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", busy, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int p0, st0, ak0, nk0;
    stretch_len = 0;
    repeat (5) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R10 lines released", {scl_oe, sda_oe}, 0);
    chk(busy == 0 && start_pend == 0, "R10 busy/start_pend", {busy, start_pend}, 0);
    chk(rx_ready == 0 && nack_flag == 0, "R10 rx_ready/nack", {rx_ready, nack_flag}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // count = 3, prompt reads, restart attempt while busy
    p0 = s_ptr; st0 = stops; ak0 = m_acks; nk0 = m_nacks;
    do_start(SLV, 3);
    chk(start_pend == 1 && busy == 1, "R3 start_pend after start", {start_pend, busy}, 3);
    while (start_pend) @(negedge clk);
    chk(rx_ready == 0, "R3 no rx event at address end", rx_ready, 0);
    for (int i = 0; i < 3; i++) begin
      read_byte(d);
      chk(d == mem(p0 + i), "R1 byte value", d, mem(p0 + i));
      if (i == 0) begin
        do_start(SLV, 1);
        chk(start_pend == 0 && busy == 1, "R9 start ignored while busy", start_pend, 0);
      end
    end
    wait_idle();
    chk(s_ptr - p0 == 3, "R5 bytes fetched count 3", s_ptr - p0, 3);
    chk(m_acks - ak0 == 2 && m_nacks - nk0 == 1, "R5 ack pattern", m_acks - ak0, 2);
    chk(stops - st0 == 1, "R5 automatic stop", stops - st0, 1);

    // run-ahead and stall, then software stop
    p0 = s_ptr;
    do_start(SLV, 0);
    while (!rx_ready) @(negedge clk);
    repeat (300) @(negedge clk);
    chk(scl_in == 0 && s_st == 2 && s_k == 7, "R2 stalled after seventh bit", s_k, 7);
    chk(rx_data == mem(p0) && rx_ready == 1, "R1 pending byte kept", rx_data, mem(p0));
    read_byte(d);
    pulse_stop();
    read_byte(d);
    chk(d == mem(p0 + 1), "R1 run-ahead byte", d, mem(p0 + 1));
    wait_idle();
    chk(s_ptr - p0 == 2, "R4 stop during stalled byte", s_ptr - p0, 2);

    // stop during first byte -> exactly one
    p0 = s_ptr;
    do_start(SLV, 0);
    while (start_pend) @(negedge clk);
    pulse_stop();
    read_byte(d);
    chk(d == mem(p0), "R4 single byte value", d, mem(p0));
    wait_idle();
    chk(s_ptr - p0 == 1, "R4 exactly one byte", s_ptr - p0, 1);

    // count = 1
    p0 = s_ptr; nk0 = m_nacks;
    do_start(SLV, 1);
    read_byte(d);
    wait_idle();
    chk(s_ptr - p0 == 1 && m_nacks - nk0 == 1, "R5 count 1 nacked", s_ptr - p0, 1);

    // address NACK
    p0 = s_ptr; st0 = stops;
    do_start(SLV ^ 7'h01, 0);
    wait_idle();
    chk(nack_flag == 1, "R7 nack flag", nack_flag, 1);
    chk(rx_ready == 0 && s_ptr == p0, "R7 no data", s_ptr - p0, 0);
    chk(stops - st0 == 1, "R7 stop issued", stops - st0, 1);

    // clock stretching
    stretch_len = 15;
    p0 = s_ptr;
    do_start(SLV, 2);
    @(negedge clk);
    chk(nack_flag == 0, "R7 flag cleared by new start", nack_flag, 0);
    for (int i = 0; i < 2; i++) begin
      read_byte(d);
      chk(d == mem(p0 + i), "R8 byte under stretching", d, mem(p0 + i));
    end
    wait_idle();
    chk(s_ptr - p0 == 2 && busy == 0, "R8 count under stretching", s_ptr - p0, 2);
    stretch_len = 0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule